// File: doc/BRIEF.md
# NAND Flash Host Front End

This block sits between a simple register bus and an 8-bit or 16-bit NAND flash device. Software writes a command byte, an address byte, a data word or a read request into one of four queue registers. Each write becomes an entry in a small ordered queue. A bus sequencer takes the entries off the queue one at a time and turns each into a flash bus cycle. Commands use a write strobe with the command latch line high. Addresses use a write strobe with the address latch line high. Data uses a plain write strobe. A read request uses a read strobe.

A read is started by writing any value to the read-request register. When the read strobe ends, the sampled word is held in a read-data register and a sticky read-ready flag sets. Software polls the queue-full status bit before every queued write. It also watches the synchronised ready/busy line and a set of write-one-to-clear event flags, which can be masked onto a single interrupt output. Strobe widths come from two delay fields in the control register, one for reads and one for writes.

Top module: `nand_host_front`

## Requirements
- R1: After reset, STATUS (address 1) reads 0x11 while the ready/busy input is high, the event flags (address 2) and the mask (address 3) read 0, chip enable is high, and both strobes are high.
- R2: A write to address 4 produces one write-strobe cycle with CLE high and ALE low. The data bus carries the low byte of the written value, and the upper byte is zero.
- R3: A write to address 5 produces one write-strobe cycle with ALE high and CLE low. The data bus carries the low byte, and the upper byte is zero.
- R4: A write to address 6 produces a write-strobe cycle with CLE and ALE both low. In 16-bit mode (CTRL bit 0 = 1) all 16 bits are driven. In 8-bit mode the upper byte is zero.
- R5: CTRL (address 0) holds the read delay in bits 4:1 and the write delay in bits 8:5. The write strobe stays low for the write delay + 1 clocks and the read strobe for the read delay + 1 clocks. Each strobe is then high for at least one clock. The two strobes are never low together.
- R6: Queued accesses reach the flash bus in the order they were written. The queue holds 4 entries. STATUS bit 1 is high while 4 entries wait, and STATUS bit 4 is high while none wait.
- R7: A queue write that arrives while STATUS bit 1 is high is dropped, and event flag bit 1 sets.
- R8: A write of any value to address 7 causes one read-strobe cycle. The sampled word goes to address 8, masked to its low byte in 8-bit mode, and event flag bit 3 sets in the same cycle.
- R9: Writing 1 to a bit of address 2 clears that flag. Writing 0 leaves it unchanged.
- R10: The ready/busy input passes through a two-flop synchroniser. STATUS bit 0 follows the synchronised value, and a rising edge on it sets event flag bit 0.
- R11: Event flag bit 2 sets when a bus cycle ends with the queue empty. The irq output is high when any event flag is set whose mask bit is also set.
- R12: Chip enable is low while the queue holds an entry or a bus cycle is in progress, and high otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational on reg_addr) |
| irq | output | 1 | Masked interrupt request |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 16 | Data bus driven to the flash |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_in | input | 16 | Data bus sampled from the flash |
| nand_rb | input | 1 | Ready/busy from the flash, high when ready |

## Verification
Assertions check on every cycle that the latch lines are never high together and that the two strobes are never low together. They also check that every strobe low is covered by chip enable, that a strobe stays high for a clock after it rises, and that the queue never holds more entries than it has room for. Further assertions check that an overflow, a completed read or a ready edge sets its event flag on the next clock. Only the bench's scenarios can show the ordering of cycles, the exact strobe widths under each delay setting, the width masking in each bus mode, the read data value and the effect of the mask and the clear writes. The bench measures these from the flash-side pins and compares them against a list of expected cycles that it builds as it issues writes.

// File: rtl/nfh_pkg.sv
package nfh_pkg;
  typedef enum logic [1:0] {K_CMD = 2'd0, K_ADDR = 2'd1, K_DATA = 2'd2, K_READ = 2'd3} kind_e;
  typedef enum logic [1:0] {S_IDLE = 2'd0, S_LOW = 2'd1, S_HIGH = 2'd2} seq_e;

  localparam int DW = 16;

  typedef struct packed {
    kind_e         kind;
    logic [DW-1:0] val;
  } entry_t;

  localparam logic [3:0] A_CTRL  = 4'h0;
  localparam logic [3:0] A_STAT  = 4'h1;
  localparam logic [3:0] A_EVT   = 4'h2;
  localparam logic [3:0] A_MASK  = 4'h3;
  localparam logic [3:0] A_CMD   = 4'h4;
  localparam logic [3:0] A_ADDR  = 4'h5;
  localparam logic [3:0] A_WDAT  = 4'h6;
  localparam logic [3:0] A_RREQ  = 4'h7;
  localparam logic [3:0] A_RDAT  = 4'h8;
endpackage

// File: rtl/nfh_queue.sv
module nfh_queue #(
  parameter int DEPTH = 4,
  parameter int W     = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp_q];

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (do_push) wp_d = (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
    if (do_pop)  rp_d = (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
    if (do_push && !do_pop) cnt_d = cnt_q + 1'b1;
    else if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= din;
  end

  AST_QUEUE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH)); // R6
endmodule

// File: rtl/nfh_rb_sync.sv
module nfh_rb_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic rb_async,
  output logic rb_sync,
  output logic rb_rise
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      meta_q <= rb_async;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rb_sync = sync_q;
  assign rb_rise = sync_q && !prev_q;
endmodule

// File: rtl/nfh_bus_seq.sv
module nfh_bus_seq
  import nfh_pkg::*;
#(
  parameter int DLYW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            q_empty,
  input  entry_t          q_head,
  output logic            q_pop,
  input  logic            wide,
  input  logic [DLYW-1:0] wr_dly,
  input  logic [DLYW-1:0] rd_dly,
  input  logic [DW-1:0]   dq_in,
  output logic            ce_n,
  output logic            cle,
  output logic            ale,
  output logic            we_n,
  output logic            re_n,
  output logic [DW-1:0]   dq_out,
  output logic            dq_oe,
  output logic            rd_done,
  output logic [DW-1:0]   rd_data,
  output logic            cyc_done
);
  localparam int HALF = DW / 2;

  seq_e            st_q, st_d;
  logic [DLYW-1:0] cnt_q, cnt_d, lim_q;
  kind_e           kind_q;
  logic [DW-1:0]   val_q, rd_q, load_val;
  logic            wide_q, load;

  always_comb begin
    case (q_head.kind)
      K_CMD, K_ADDR: load_val = {{(DW-HALF){1'b0}}, q_head.val[HALF-1:0]};
      K_DATA:        load_val = wide ? q_head.val : {{(DW-HALF){1'b0}}, q_head.val[HALF-1:0]};
      default:       load_val = '0;
    endcase
  end

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    load    = 1'b0;
    rd_done = 1'b0;
    case (st_q)
      S_IDLE: if (!q_empty) begin
        st_d  = S_LOW;
        cnt_d = '0;
        load  = 1'b1;
      end
      S_LOW: if (cnt_q == lim_q) begin
        st_d    = S_HIGH;
        rd_done = (kind_q == K_READ);
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      cnt_q <= '0;
      rd_q  <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      if (rd_done) rd_q <= wide_q ? dq_in : {{(DW-HALF){1'b0}}, dq_in[HALF-1:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      kind_q <= q_head.kind;
      val_q  <= load_val;
      wide_q <= wide;
      lim_q  <= (q_head.kind == K_READ) ? rd_dly : wr_dly;
    end
  end

  assign q_pop    = load;
  assign cyc_done = (st_q == S_HIGH);
  assign ce_n     = q_empty && (st_q == S_IDLE);
  assign cle      = (st_q != S_IDLE) && (kind_q == K_CMD);
  assign ale      = (st_q != S_IDLE) && (kind_q == K_ADDR);
  assign we_n     = !((st_q == S_LOW) && (kind_q != K_READ));
  assign re_n     = !((st_q == S_LOW) && (kind_q == K_READ));
  assign dq_oe    = (st_q != S_IDLE) && (kind_q != K_READ);
  assign dq_out   = dq_oe ? val_q : '0;
  assign rd_data  = rd_q;

  AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle && ale)); // R2
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !re_n)); // R5
  AST_WE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |=> (we_n && re_n)); // R5
  AST_RE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(re_n) |=> (we_n && re_n)); // R5
  AST_CE_COVER: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n || !re_n) |-> !ce_n); // R12
endmodule

// File: rtl/nand_host_front.sv
module nand_host_front
  import nfh_pkg::*;
#(
  parameter int QDEPTH = 4,
  parameter int DLYW   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [3:0]    reg_addr,
  input  logic [15:0]   reg_wdata,
  output logic [15:0]   reg_rdata,
  output logic          irq,
  output logic          nand_ce_n,
  output logic          nand_cle,
  output logic          nand_ale,
  output logic          nand_we_n,
  output logic          nand_re_n,
  output logic [15:0]   nand_dq_out,
  output logic          nand_dq_oe,
  input  logic [15:0]   nand_dq_in,
  input  logic          nand_rb
);
  localparam int CTLW  = 1 + 2 * DLYW;
  localparam int RD_LO = 1;
  localparam int WR_LO = 1 + DLYW;
  localparam int NEVT  = 5;

  logic [CTLW-1:0] ctrl_q, ctrl_d;
  logic [NEVT-1:0] evt_q, evt_d, mask_q, mask_d, evt_set, evt_clr;
  logic            q_wr, q_full, q_empty, q_pop;
  entry_t          q_in, q_head;
  logic            rb_sync, rb_rise, rd_done, cyc_done;
  logic [DW-1:0]   rd_data;

  assign q_wr = reg_wr && (reg_addr == A_CMD || reg_addr == A_ADDR ||
                           reg_addr == A_WDAT || reg_addr == A_RREQ);

  always_comb begin
    case (reg_addr)
      A_CMD:   q_in.kind = K_CMD;
      A_ADDR:  q_in.kind = K_ADDR;
      A_WDAT:  q_in.kind = K_DATA;
      default: q_in.kind = K_READ;
    endcase
    q_in.val = reg_wdata;
  end

  nfh_queue #(.DEPTH(QDEPTH), .W($bits(entry_t))) u_queue (
    .clk(clk), .rst_n(rst_n), .push(q_wr), .pop(q_pop),
    .din(q_in), .dout(q_head), .full(q_full), .empty(q_empty)
  );

  nfh_bus_seq #(.DLYW(DLYW)) u_seq (
    .clk(clk), .rst_n(rst_n), .q_empty(q_empty), .q_head(q_head), .q_pop(q_pop),
    .wide(ctrl_q[0]), .wr_dly(ctrl_q[WR_LO +: DLYW]), .rd_dly(ctrl_q[RD_LO +: DLYW]),
    .dq_in(nand_dq_in), .ce_n(nand_ce_n), .cle(nand_cle), .ale(nand_ale),
    .we_n(nand_we_n), .re_n(nand_re_n), .dq_out(nand_dq_out), .dq_oe(nand_dq_oe),
    .rd_done(rd_done), .rd_data(rd_data), .cyc_done(cyc_done)
  );

  nfh_rb_sync u_rb (
    .clk(clk), .rst_n(rst_n), .rb_async(nand_rb), .rb_sync(rb_sync), .rb_rise(rb_rise)
  );

  always_comb begin
    evt_set = {1'b0, rd_done, cyc_done && q_empty, q_wr && q_full, rb_rise};
    evt_clr = (reg_wr && reg_addr == A_EVT) ? reg_wdata[NEVT-1:0] : '0;
    evt_d   = (evt_q & ~evt_clr) | evt_set;
    ctrl_d  = (reg_wr && reg_addr == A_CTRL) ? reg_wdata[CTLW-1:0] : ctrl_q;
    mask_d  = (reg_wr && reg_addr == A_MASK) ? reg_wdata[NEVT-1:0] : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      evt_q  <= '0;
      mask_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      evt_q  <= evt_d;
      mask_q <= mask_d;
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = 16'(ctrl_q);
      A_STAT:  reg_rdata = {11'd0, q_empty, 2'b00, q_full, rb_sync};
      A_EVT:   reg_rdata = 16'(evt_q);
      A_MASK:  reg_rdata = 16'(mask_q);
      A_RDAT:  reg_rdata = rd_data;
      default: reg_rdata = '0;
    endcase
  end

  assign irq = |(evt_q & mask_q);

  AST_OVF_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (q_wr && q_full) |=> evt_q[1]); // R7
  AST_READ_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> evt_q[3]); // R8
  AST_RB_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    rb_rise |=> evt_q[0]); // R10
endmodule

// File: tb/test_nand_host_front.sv
module test_nand_host_front;
  logic        clk, rst_n, reg_wr, irq;
  logic [3:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata, nand_dq_out, nand_dq_in;
  logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe, nand_rb;

  nand_host_front i_nand_host_front (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_out(nand_dq_out),
    .nand_dq_oe(nand_dq_oe), .nand_dq_in(nand_dq_in), .nand_rb(nand_rb)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0, errors = 0, ce_bad = 0;
  int exp_n = 0, mon_n = 0;
  logic [1:0]  exp_k [256];
  logic [15:0] exp_v [256];
  int          exp_l [256];
  logic sh_wide = 1'b0;
  int   sh_wr = 0, sh_rd = 0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  function automatic logic [15:0] exp_val(input logic [1:0] k, input logic [15:0] v, input logic w);
    if (k == 2'd3) return 16'h0;
    if (k == 2'd2 && w) return v;
    return {8'h00, v[7:0]};
  endfunction

  // bus monitor: measures each strobe pulse and compares with the expected list
  logic pw = 1'b1, pr = 1'b1;
  int lw = 0, lr = 0;
  logic [1:0]  ck;
  logic [15:0] cv;
  task automatic got(input logic [1:0] k, input logic [15:0] v, input int len);
    if (mon_n >= exp_n) begin
      chk(0, "R6 unexpected cycle", k, 0);
    end else begin
      chk(k == exp_k[mon_n], "R2/R3/R4/R6 cycle kind", k, exp_k[mon_n]);
      chk(v == exp_v[mon_n], "R2/R3/R4 bus value", v, exp_v[mon_n]);
      chk(len == exp_l[mon_n], "R5 strobe width", len, exp_l[mon_n]);
    end
    mon_n++;
  endtask

  always @(negedge clk) if (rst_n) begin
    if ((!nand_we_n || !nand_re_n) && nand_ce_n) ce_bad++;
    if (!nand_we_n) begin
      if (pw) begin
        lw = 1; cv = nand_dq_out;
        ck = nand_cle ? 2'd0 : (nand_ale ? 2'd1 : 2'd2);
      end else lw++;
    end else if (!pw) got(ck, cv, lw);
    if (!nand_re_n) begin
      if (pr) lr = 1; else lr++;
    end else if (!pr) got(2'd3, 16'h0, lr);
    pw = nand_we_n;
    pr = nand_re_n;
  end

  // host access tasks, called at a falling edge
  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic expect_cyc(input logic [3:0] a, input logic [15:0] d);
    logic [1:0] k;
    k = 2'(a - 4'h4);
    exp_k[exp_n] = k;
    exp_v[exp_n] = exp_val(k, d, sh_wide);
    exp_l[exp_n] = (k == 2'd3) ? sh_rd + 1 : sh_wr + 1;
    exp_n++;
  endtask

  task automatic qwr(input logic [3:0] a, input logic [15:0] d);
    logic [15:0] s;
    rd(4'h1, s);
    while (s[1]) begin
      @(negedge clk);
      rd(4'h1, s);
    end
    wr(a, d);
    expect_cyc(a, d);
  endtask

  task automatic wait_idle();
    logic [15:0] s;
    rd(4'h1, s);
    while (!s[4] || !nand_ce_n) begin
      @(negedge clk);
      rd(4'h1, s);
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic set_ctrl(input logic w, input int rdl, input int wrl);
    wait_idle();
    sh_wide = w; sh_rd = rdl; sh_wr = wrl;
    wr(4'h0, {7'd0, 4'(wrl), 4'(rdl), w});
  endtask

  task automatic do_read();
    logic [15:0] v, s;
    int n;
    v = 16'($urandom);
    nand_dq_in = v;
    qwr(4'h7, 16'($urandom));
    n = 0;
    rd(4'h2, s);
    while (!s[3] && n < 200) begin
      @(negedge clk);
      n++;
      rd(4'h2, s);
    end
    rd(4'h8, s);
    chk(s == (sh_wide ? v : {8'h00, v[7:0]}), "R8 read data", s, sh_wide ? v : {8'h00, v[7:0]});
    wr(4'h2, 16'h0008);
    rd(4'h2, s);
    chk(s[3] == 1'b0, "R9 read flag cleared", s[3], 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] s;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 4'h0; reg_wdata = 16'h0;
    nand_dq_in = 16'h0; nand_rb = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(4'h1, s); chk(s == 16'h0011, "R1 status", s, 16'h11);
    rd(4'h2, s); chk(s == 16'h0, "R1 flags", s, 0);
    rd(4'h3, s); chk(s == 16'h0, "R1 mask", s, 0);
    chk(nand_ce_n && nand_we_n && nand_re_n, "R1 bus idle", {nand_ce_n, nand_we_n, nand_re_n}, 7);
    chk(irq == 1'b0, "R1 irq low", irq, 0);

    // directed cycles R2 R3 R4
    qwr(4'h4, 16'hAB90);
    qwr(4'h5, 16'h1234);
    qwr(4'h6, 16'hBEEF);
    set_ctrl(1'b1, 2, 1);
    qwr(4'h6, 16'hBEEF);
    do_read();
    set_ctrl(1'b0, 3, 0);
    do_read();

    // R11 empty edge flag after drain
    wait_idle();
    rd(4'h2, s); chk(s[2] == 1'b1, "R11 drain flag", s[2], 1);
    chk(nand_ce_n == 1'b1, "R12 ce idle", nand_ce_n, 1);
    wr(4'h2, 16'h001F);

    // R6 R7 overflow: 6 back-to-back writes with long strobes
    set_ctrl(1'b1, 0, 15);
    for (int i = 0; i < 6; i++) begin
      wr(4'h4, 16'(8'h10 + i));
      if (i < 5) expect_cyc(4'h4, 16'(8'h10 + i));
    end
    rd(4'h1, s); chk(s[1] == 1'b1 && s[4] == 1'b0, "R6 full status", s, 16'h0002);
    chk(nand_ce_n == 1'b0, "R12 ce busy", nand_ce_n, 0);
    rd(4'h2, s); chk(s[1] == 1'b1, "R7 overflow flag", s[1], 1);
    chk(irq == 1'b0, "R11 masked irq", irq, 0);
    wr(4'h3, 16'h0002);
    chk(irq == 1'b1, "R11 unmasked irq", irq, 1);
    wr(4'h2, 16'h0000);
    rd(4'h2, s); chk(s[1] == 1'b1, "R9 zero keeps flag", s[1], 1);
    wr(4'h2, 16'h0002);
    rd(4'h2, s); chk(s[1] == 1'b0, "R9 one clears flag", s[1], 0);
    chk(irq == 1'b0, "R11 irq after clear", irq, 0);
    wr(4'h3, 16'h0000);
    wait_idle();

    // R10 ready/busy
    nand_rb = 1'b0;
    repeat (4) @(negedge clk);
    rd(4'h1, s); chk(s[0] == 1'b0, "R10 busy seen", s[0], 0);
    wr(4'h2, 16'h001F);
    nand_rb = 1'b1;
    @(negedge clk);
    rd(4'h2, s); chk(s[0] == 1'b0, "R10 not yet synced", s[0], 0);
    repeat (3) @(negedge clk);
    rd(4'h1, s); chk(s[0] == 1'b1, "R10 ready seen", s[0], 1);
    rd(4'h2, s); chk(s[0] == 1'b1, "R10 edge flag", s[0], 1);
    wr(4'h2, 16'h001F);

    // random mix
    for (int blk = 0; blk < 8; blk++) begin
      set_ctrl(1'($urandom), int'($urandom % 4), int'($urandom % 4));
      for (int i = 0; i < 12; i++) begin
        int k;
        k = int'($urandom % 5);
        if (k == 4) do_read();
        else qwr(4'(4 + (k % 3)), 16'($urandom));
      end
    end
    wait_idle();
    chk(mon_n == exp_n, "R6 all cycles seen", mon_n, exp_n);
    chk(ce_bad == 0, "R12 ce during strobe", ce_bad, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule